// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Controller

This block is the digital control of a byte-wide serial EEPROM that answers as a slave on a two-wire I2C bus. A system clock oversamples the SCL and SDA lines. From those samples the block finds START and STOP conditions and shifts in the slave address byte. It checks the fixed device prefix and the strap-selected bits, then captures a word address. It gathers write data in a 16-byte page buffer and commits that buffer to a behavioural byte array when the write ends. It also returns data for current-address, random and sequential reads.

The array holds 256, 512, 1024 or 2048 bytes, chosen by the `WORDS` parameter. In denser arrays the upper word-address bits replace strap bits in the slave address byte. A write-protect input locks the upper half of the array. A cycle count, `PROG_CYCLES`, stands in for the self-timed programming interval. The slave ignores the bus for that whole interval.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: A falling SDA while SCL is high (START) puts the block into the slave-address phase from any state except programming, even partway through a byte. A rising SDA while SCL is high (STOP) ends the transaction.
- R2: The slave address byte is received MSB first. Bits 7..4 must equal 1010. Bit 0 is R/W, where 1 means read. Bits 3..1 hold {a10,a9,a8} for WORDS=2048, {A2,a9,a8} for 1024, {A2,A1,a8} for 512 and {A2,A1,A0} for 256. Only the strap positions (A2..A0 from `strap_i[2:0]`) are compared. A mismatch gets no acknowledge, and SDA stays high on the ninth clock.
- R3: For each accepted byte the slave pulls SDA low from the falling SCL edge after bit 8 until the falling edge that ends the ninth clock. After that it releases SDA.
- R4: The word-address byte after a write-direction slave address sets address bits 7..0. An accepted slave address loads the address bits above bit 7 from its bits 3..1. A read with no word address returns the byte at the current address.
- R5: Write data bytes go into a 16-byte page buffer at the low 4 address bits. Those bits then increment and wrap within the page, so bytes past the 16th overwrite earlier buffer entries.
- R6: A STOP that ends a write holding at least one data byte starts a program cycle of `PROG_CYCLES` clocks. During the cycle SDA is released, the slave does not acknowledge its address, and START and STOP are ignored. Once the cycle ends, the written bytes read back.
- R7: A write carrying only the slave address and word address starts no program cycle. The slave acknowledges the next START plus address at once.
- R8: While `wp_i` is high, data bytes aimed at the upper half of the array (top address bit set) are acknowledged but leave the array unchanged. Bytes aimed at the lower half are still written.
- R9: Read data is driven MSB first. After each byte the master acknowledges (SDA low on the ninth clock), the address increments and the next byte follows. The address rolls over from WORDS-1 to 0.
- R10: A NACK on the ninth clock of a read ends the transfer. The slave releases SDA and does not drive it again before a new START. A NACK leaves the address unchanged.
- R11: The slave's SDA pull changes only while the sampled SCL is low.
- R12: After reset the slave is idle and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 3 | Device address straps A2..A0; unconnected pins are tied to 0 |
| wp_i | input | 1 | Write protect for the upper half of the array |
| sda_pull_o | output | 1 | Open-drain drive: 1 pulls SDA low |

## Verification
The bus is sampled through one register and compared with a second one. Each detected edge updates the state register. So `sda_pull_o` responds two system clocks after an SCL or SDA change on the pins. The bench holds every SCL quarter period for four clocks, changes data only while SCL is low, and reads the bus in the middle of the SCL-high phase. It therefore samples acknowledge and read bits well after they settle. The program cycle starts two clocks after the SDA rise that forms STOP and lasts `PROG_CYCLES` clocks. The busy check issues its address within about 150 clocks of that STOP. The readback after a write waits `PROG_CYCLES`+20 clocks.

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave #(
  parameter int WORDS       = 256,
  parameter int PAGE_BITS   = 4,
  parameter int PROG_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_pull_o
);

  localparam int AW = $clog2(WORDS);
  localparam int HB = AW - 8;
  localparam int PG = 1 << PAGE_BITS;
  localparam int CW = $clog2(PROG_CYCLES + 1);
  localparam logic [10:0] AMASK = 11'(WORDS - 1);
  localparam logic [2:0]  HMASK = 3'((1 << HB) - 1);

  localparam logic [1:0] K_DEV = 2'd0, K_WORD = 2'd1, K_DATA = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_RACK, S_BUSY} state_t;

  state_t          st;
  logic [1:0]      kind;
  logic [3:0]      bitcnt;
  logic [7:0]      shreg;
  logic [10:0]     addr;
  logic            rw, wr_act, got_data, mack;
  logic [PG-1:0]   vmask;
  logic [7:0]      pbuf [PG];
  logic [7:0]      mem  [WORDS];
  logic [CW-1:0]   bcnt;
  logic            scl_q, scl_p, sda_q, sda_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1; scl_p <= 1'b1; sda_q <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_q <= scl_i; scl_p <= scl_q; sda_q <= sda_i; sda_p <= sda_q;
    end
  end

  wire scl_rise = scl_q & ~scl_p;
  wire scl_fall = ~scl_q & scl_p;
  wire start_c  = scl_q & scl_p & sda_p & ~sda_q;
  wire stop_c   = scl_q & scl_p & ~sda_p & sda_q;

  wire                 dev_ok   = (shreg[7:4] == 4'b1010) && (((shreg[3:1] ^ strap_i) & ~HMASK) == 3'd0);
  wire                 prog_go  = stop_c && (st != S_BUSY) && wr_act && got_data;
  wire                 protect  = wp_i & addr[AW-1];
  wire [PAGE_BITS-1:0] pg_idx   = addr[PAGE_BITS-1:0];
  wire [10:0]          addr_inc = (addr + 11'd1) & AMASK;
  wire [7:0]           rd_data  = mem[addr[AW-1:0]];
  wire [7:0]           rd_next  = mem[addr_inc[AW-1:0]];

  assign sda_pull_o = (st == S_ACK) | ((st == S_TX) & ~shreg[7]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_DEV; bitcnt <= 4'd0; shreg <= 8'd0;
      addr <= 11'd0; rw <= 1'b0; wr_act <= 1'b0; got_data <= 1'b0;
      mack <= 1'b0; vmask <= '0; bcnt <= '0;
    end else if (st == S_BUSY) begin
      if (bcnt == CW'(PROG_CYCLES - 1)) begin
        st <= S_IDLE; bcnt <= '0;
      end else begin
        bcnt <= bcnt + 1'b1;
      end
    end else if (start_c) begin
      st <= S_RX; kind <= K_DEV; bitcnt <= 4'd0; wr_act <= 1'b0;
    end else if (stop_c) begin
      st <= prog_go ? S_BUSY : S_IDLE; wr_act <= 1'b0; bcnt <= '0;
    end else begin
      case (st)
        S_RX: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_q};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            case (kind)
              K_DEV: begin
                if (dev_ok) begin
                  addr     <= {shreg[3:1] & HMASK, addr[7:0]};
                  rw       <= shreg[0];
                  wr_act   <= ~shreg[0];
                  got_data <= 1'b0;
                  vmask    <= '0;
                  st       <= S_ACK;
                end else begin
                  st <= S_IDLE;
                end
              end
              K_WORD: begin
                addr[7:0] <= shreg;
                st        <= S_ACK;
              end
              default: begin
                pbuf[pg_idx]  <= shreg;
                vmask[pg_idx] <= ~protect;
                got_data      <= 1'b1;
                addr          <= {addr[10:PAGE_BITS], pg_idx + 1'b1};
                st            <= S_ACK;
              end
            endcase
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            bitcnt <= 4'd0;
            if (rw) begin
              shreg <= rd_data;
              st    <= S_TX;
            end else begin
              st   <= S_RX;
              kind <= (kind == K_DEV) ? K_WORD : K_DATA;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            shreg  <= {shreg[6:0], 1'b1};
            bitcnt <= bitcnt + 4'd1;
            if (bitcnt == 4'd7) st <= S_RACK;
          end
        end
        S_RACK: begin
          if (scl_rise) mack <= ~sda_q;
          if (scl_fall) begin
            if (mack) begin
              addr   <= addr_inc;
              shreg  <= rd_next;
              bitcnt <= 4'd0;
              st     <= S_TX;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (prog_go) begin
      for (int i = 0; i < PG; i++) begin
        if (vmask[i]) mem[AW'({addr[10:PAGE_BITS], PAGE_BITS'(i)})] <= pbuf[i];
      end
    end
  end

  assert_pull_steady_scl_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && $past(scl_q)) |-> $stable(sda_pull_o));

  assert_ack_after_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACK && $past(st) != S_ACK) |-> $past(bitcnt) == 4'd8);

  assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BUSY && bcnt != CW'(PROG_CYCLES - 1)) |=> st == S_BUSY);

  assert_busy_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BUSY) |-> (32'(bcnt) < PROG_CYCLES));

  assert_prog_needs_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == S_BUSY) |-> $past(got_data));

  assert_tx_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TX) |-> bitcnt < 4'd8);

endmodule

// File: tb/test_eeprom_i2c_slave.sv
module test_eeprom_i2c_slave;
  localparam int PROG = 300;
  localparam int Q    = 4;
  localparam logic [15:0] VEC [6] = '{16'h0011, 16'h05C3, 16'h3F7E, 16'h4001, 16'h7AA5, 16'hFF96};

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1, sel = 1'b0, wp = 1'b0;
  logic pull_a, pull_b, sda_a, sda_b, bus;
  int checks = 0, errors = 0;
  logic [7:0] wdata [32];
  logic [7:0] rdata [32];

  always #4 clk = ~clk;

  assign sda_a = (sel ? 1'b1 : m_sda) & ~pull_a;
  assign sda_b = (sel ? m_sda : 1'b1) & ~pull_b;
  assign bus   = sel ? sda_b : sda_a;

  eeprom_i2c_slave #(.WORDS(256), .PAGE_BITS(4), .PROG_CYCLES(PROG)) i_eeprom_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_a), .strap_i(3'b101),
    .wp_i(wp), .sda_pull_o(pull_a));

  eeprom_i2c_slave #(.WORDS(2048), .PAGE_BITS(4), .PROG_CYCLES(PROG)) i_eeprom_i2c_slave_2k (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_b), .strap_i(3'b000),
    .wp_i(1'b0), .sda_pull_o(pull_b));

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic q;
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic i2c_start;
    m_sda = 1'b1; q; scl = 1'b1; q; m_sda = 1'b0; q; scl = 1'b0; q;
  endtask

  task automatic i2c_stop;
    m_sda = 1'b0; q; scl = 1'b1; q; m_sda = 1'b1; q;
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; q; scl = 1'b1; q; q; scl = 1'b0; q;
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; q; scl = 1'b1; q; b = bus; q; scl = 1'b0; q;
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic rbyte(input logic ack_it, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~ack_it);
  endtask

  task automatic wr(input logic [7:0] dev, input logic [7:0] a, input int n, output logic ok);
    logic k;
    ok = 1'b1;
    i2c_start;
    wbyte(dev, k); ok &= k;
    wbyte(a, k);   ok &= k;
    for (int i = 0; i < n; i++) begin
      wbyte(wdata[i], k); ok &= k;
    end
    i2c_stop;
  endtask

  task automatic rd(input logic [7:0] dev, input logic [7:0] a, input int n, output logic ok);
    logic k;
    ok = 1'b1;
    i2c_start;
    wbyte(dev & 8'hFE, k); ok &= k;
    wbyte(a, k);           ok &= k;
    i2c_start;
    wbyte(dev | 8'h01, k); ok &= k;
    for (int i = 0; i < n; i++) rbyte(i != n - 1, rdata[i]);
    i2c_stop;
  endtask

  task automatic wait_prog;
    repeat (PROG + 20) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    summary;
    $finish;
  end

  initial begin
    logic ok, k;
    logic [7:0] d;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    q;
    chk("R12 SDA released after reset", {7'd0, bus}, 8'd1);

    // R4 / R6: single-byte writes then random reads from a vector table
    for (int v = 0; v < 6; v++) begin
      wdata[0] = VEC[v][7:0];
      wr(8'hAA, VEC[v][15:8], 1, ok);
      chk("R4 write acknowledged", {7'd0, ok}, 8'd1);
      wait_prog;
      rd(8'hAA, VEC[v][15:8], 1, ok);
      chk("R4 random read data", rdata[0], VEC[v][7:0]);
    end

    // R2: wrong strap bits and wrong prefix are not acknowledged
    i2c_start; wbyte(8'hA0, k); i2c_stop;
    chk("R2 strap mismatch NACK", {7'd0, k}, 8'd0);
    i2c_start; wbyte(8'hBA, k); i2c_stop;
    chk("R2 prefix mismatch NACK", {7'd0, k}, 8'd0);
    i2c_start; wbyte(8'hAE, k); i2c_stop;
    chk("R2 A1 strap mismatch NACK", {7'd0, k}, 8'd0);

    // R3: ACK then release before next byte; R7: no-data write starts no program
    i2c_start; wbyte(8'hAA, k);
    chk("R3 address ACK", {7'd0, k}, 8'd1);
    m_sda = 1'b1; q;
    chk("R3 SDA released after ninth clock", {7'd0, bus}, 8'd1);
    wbyte(8'h05, k);
    i2c_stop;
    i2c_start; wbyte(8'hAB, k);
    chk("R7 ACK right after address-only write", {7'd0, k}, 8'd1);
    rbyte(1'b0, d); i2c_stop;
    chk("R4 current address read", d, 8'hC3);

    // R6: busy during program cycle
    wdata[0] = 8'h77;
    wr(8'hAA, 8'h50, 1, ok);
    i2c_start; wbyte(8'hAA, k); i2c_stop;
    chk("R6 no ACK while programming", {7'd0, k}, 8'd0);
    wait_prog;
    rd(8'hAA, 8'h50, 1, ok);
    chk("R6 ACK after program cycle", {7'd0, ok}, 8'd1);
    chk("R6 programmed data", rdata[0], 8'h77);

    // R5: page overflow wraps and overwrites
    for (int i = 0; i < 18; i++) wdata[i] = 8'h80 + 8'(i);
    wr(8'hAA, 8'h20, 18, ok);
    wait_prog;
    rd(8'hAA, 8'h20, 16, ok);
    for (int i = 0; i < 16; i++)
      chk("R5 page wrap data", rdata[i], (i < 2) ? 8'h90 + 8'(i) : 8'h80 + 8'(i));
    wdata[0] = 8'h61; wdata[1] = 8'h62; wdata[2] = 8'h63;
    wr(8'hAA, 8'h4E, 3, ok);
    wait_prog;
    rd(8'hAA, 8'h40, 1, ok);
    chk("R5 low bits wrap to page start", rdata[0], 8'h63);

    // R8: write protect of the upper half
    wdata[0] = 8'h44; wr(8'hAA, 8'h90, 1, ok); wait_prog;
    wp = 1'b1;
    wdata[0] = 8'h33; wr(8'hAA, 8'h90, 1, ok); wait_prog;
    chk("R8 blocked byte still acknowledged", {7'd0, ok}, 8'd1);
    wdata[0] = 8'h55; wr(8'hAA, 8'h10, 1, ok); wait_prog;
    wp = 1'b0;
    rd(8'hAA, 8'h90, 1, ok);
    chk("R8 protected byte unchanged", rdata[0], 8'h44);
    rd(8'hAA, 8'h10, 1, ok);
    chk("R8 lower half written under WP", rdata[0], 8'h55);

    // R9: sequential read rolls over
    rd(8'hAA, 8'hFF, 2, ok);
    chk("R9 top byte", rdata[0], 8'h96);
    chk("R9 rollover to address 0", rdata[1], 8'h11);

    // R10: NACK ends read, slave stays off the bus
    i2c_start; wbyte(8'hAA, k); wbyte(8'h00, k);
    i2c_start; wbyte(8'hAB, k); rbyte(1'b0, d);
    chk("R10 read before NACK", d, 8'h11);
    begin
      logic [7:0] seen;
      for (int i = 7; i >= 0; i--) begin
        get_bit(k);
        seen[i] = k;
      end
      chk("R10 SDA released after NACK", seen, 8'hFF);
    end
    i2c_stop;

    // R1: START mid-byte restarts address phase
    i2c_start;
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    i2c_start; wbyte(8'hAB, k);
    chk("R1 ACK after mid-byte START", {7'd0, k}, 8'd1);
    rbyte(1'b0, d); i2c_stop;
    chk("R1 read after restart", d, 8'h11);

    // R2 / R4: 2048-word array takes a10..a8 from the address byte
    sel = 1'b1;
    wdata[0] = 8'h5A; wr(8'hAA, 8'h33, 1, ok); wait_prog;
    chk("R2 dense array ignores straps", {7'd0, ok}, 8'd1);
    wdata[0] = 8'hA5; wr(8'hA4, 8'h33, 1, ok); wait_prog;
    rd(8'hAA, 8'h33, 1, ok);
    chk("R4 upper bits 101 select block", rdata[0], 8'h5A);
    rd(8'hA4, 8'h33, 1, ok);
    chk("R4 upper bits 010 select block", rdata[0], 8'hA5);
    sel = 1'b0;

    summary;
    $finish;
  end
endmodule